// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block is a synthesizable model of a three-wire serial EEPROM slave. A host selects it with a chip-select pin, clocks instruction bits into a data-in pin on the rising edges of a serial clock, and reads results on a data-out pin. Every instruction opens with a start bit. An opcode and a word address follow it, and some instructions also carry a data word. The block can read one word, program one word, erase one word, erase the whole array, fill the whole array with one pattern, and set or clear a write-enable latch. Every command that modifies the array is gated by that latch.

The serial clock and chip select are sampled in the system clock domain, so SK must run slower than the system clock. A parameter selects the organization: 128 words of 8 bits, or 64 words of 16 bits. Each modifying command starts a self-timed busy window of a fixed number of system clocks. While that window runs, the host can lower and raise chip select to make the data-out pin report busy or ready.

Top module: `serial_eeprom`

## Requirements
- R1: After reset every word holds all ones, the write-enable latch is clear, and the data-out pin is not driven (`do_en_o` = 0).
- R2: While chip select is high, zero bits before the start bit are ignored. An instruction is a start bit of 1, a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended), and an address sent most significant bit first. The address is 7 bits wide in x8 organization and 6 bits wide in x16 organization. All bits are taken on SK rising edges.
- R3: After the last address bit of a read, DO drives a 0 dummy bit. On each of the following SK rising edges it drives the next bit of the stored word, most significant bit first. Reads work whether the latch is set or clear.
- R4: A write with the latch set stores the data word once its last bit (8th or 16th) has been shifted in, and it starts a busy window.
- R5: An erase with the latch set makes the addressed word all ones.
- R6: For an extended command, the two top address bits select the operation. 11 sets the write-enable latch and 00 clears it.
- R7: Extended code 10 with the latch set makes every word all ones.
- R8: Extended code 01 with the latch set writes the data word that follows the address into every location.
- R9: With the latch clear, write, erase, erase-all and fill leave the array unchanged and start no busy window.
- R10: The busy window lasts `TPROG_CYCLES` system clocks. It starts on the clock after the edge that finishes the command. No instruction is accepted while it runs.
- R11: If chip select goes from low to high during a busy window, DO is driven for the rest of that selection: 0 while busy, then 1 once the window ends. No instruction bits are accepted in that selection.
- R12: If chip select rises while no busy window is running, DO is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled by clk_i |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_en_o | output | 1 | High while DO is driven |

## Verification
On every cycle, the assertions check the following. Each programming pulse requires the latch to be set and arrives only while the array is idle. A programming pulse always leads to a busy window. A status selection can only begin on a chip-select rise during a busy window. Reads never begin while busy. Deselection releases DO on the next clock. Whether the stored data is correct, the exact length of the busy window, the lockout during polling, and the effect of the latch on each modifying command are shown only by the bench's scenarios. There, a behavioural model compares DO and its enable on every clock and follows each command with read-backs.

// File: rtl/seep_pkg.sv
package seep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPCODE,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_HOLD
   } seep_state_e;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } seep_op_e;

   typedef enum logic [1:0] {
      EX_LOCK   = 2'b00,
      EX_FILL   = 2'b01,
      EX_CLEAR  = 2'b10,
      EX_UNLOCK = 2'b11
   } seep_ext_e;

   function automatic int unsigned addr_width(input bit wide, input int unsigned narrow_bits);
      return wide ? narrow_bits - 1 : narrow_bits;
   endfunction

   function automatic int unsigned word_width(input bit wide);
      return wide ? 16 : 8;
   endfunction

endpackage

// File: rtl/seep_pin_edges.sv
module seep_pin_edges (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_i,
   input  logic sk_i,
   output logic sk_rise_o,
   output logic cs_rise_o
);

   logic sk_q;
   logic cs_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sk_q <= 1'b0;
         cs_q <= 1'b0;
      end else begin
         sk_q <= sk_i;
         cs_q <= cs_i;
      end
   end

   // serial clock events only count while selected
   assign sk_rise_o = sk_i & ~sk_q & cs_i;
   assign cs_rise_o = cs_i & ~cs_q;

endmodule

// File: rtl/seep_prog_timer.sv
module seep_prog_timer #(
   parameter int unsigned TPROG_CYCLES = 40
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);

   localparam int unsigned CW = $clog2(TPROG_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CW'(TPROG_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_o) else $error("programming started during busy window"); // R10
   AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o) else $error("no busy window after programming pulse"); // R4

endmodule

// File: rtl/seep_array.sv
module seep_array #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_one_i,
   input  logic          we_all_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] word_rd [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DW-1:0] q;
      logic          hit;

      assign hit = we_all_i | (we_one_i & (wr_addr_i == AW'(w)));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q <= '1;
         end else if (hit) begin
            q <= wr_data_i;
         end
      end

      assign word_rd[w] = q;
   end

   assign rd_data_o = word_rd[rd_addr_i];

   AST_SINGLE_WRITE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_one_i && we_all_i)) else $error("single and whole-array write together"); // R8

endmodule

// File: rtl/seep_cmd_ctrl.sv
module seep_cmd_ctrl
   import seep_pkg::*;
#(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cs_i,
   input  logic          di_i,
   input  logic          sk_rise_i,
   input  logic          cs_rise_i,
   input  logic          busy_i,
   input  logic [DW-1:0] rd_data_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          we_one_o,
   output logic          we_all_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          do_en_o,
   output logic          do_o
);

   localparam int unsigned LONGEST = (AW > DW) ? AW : DW;
   localparam int unsigned BCW     = $clog2(LONGEST);

   seep_state_e   state_q;
   logic [BCW-1:0] bitc_q;
   logic [1:0]    opc_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] rsh_q;
   logic          rd_en_q;
   logic          rd_bit_q;
   logic          wel_q;
   logic          poll_q;
   logic          we_one_q;
   logic          we_all_q;
   logic [AW-1:0] wa_q;
   logic [DW-1:0] wd_q;

   logic [AW-1:0] a_next;
   logic [DW-1:0] d_next;
   logic [1:0]    ext_sel;
   logic          addr_last;
   logic          data_last;

   assign a_next    = {addr_q[AW-2:0], di_i};
   assign d_next    = {data_q[DW-2:0], di_i};
   assign ext_sel   = a_next[AW-1 -: 2];
   assign addr_last = (bitc_q == BCW'(AW - 1));
   assign data_last = (bitc_q == BCW'(DW - 1));
   assign rd_addr_o = a_next;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         bitc_q   <= '0;
         opc_q    <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         rsh_q    <= '0;
         rd_en_q  <= 1'b0;
         rd_bit_q <= 1'b0;
         wel_q    <= 1'b0;
         poll_q   <= 1'b0;
         we_one_q <= 1'b0;
         we_all_q <= 1'b0;
         wa_q     <= '0;
         wd_q     <= '0;
      end else begin
         we_one_q <= 1'b0;
         we_all_q <= 1'b0;
         if (!cs_i) begin
            state_q  <= ST_IDLE;
            rd_en_q  <= 1'b0;
            rd_bit_q <= 1'b0;
            poll_q   <= 1'b0;
         end else begin
            if (cs_rise_i && busy_i) begin
               poll_q <= 1'b1;
            end
            if (sk_rise_i) begin
               unique case (state_q)
                  ST_IDLE: begin
                     if (di_i && !busy_i && !poll_q) begin
                        state_q <= ST_OPCODE;
                        bitc_q  <= '0;
                     end
                  end
                  ST_OPCODE: begin
                     opc_q <= {opc_q[0], di_i};
                     if (bitc_q == BCW'(1)) begin
                        state_q <= ST_ADDR;
                        bitc_q  <= '0;
                     end else begin
                        bitc_q <= bitc_q + 1'b1;
                     end
                  end
                  ST_ADDR: begin
                     addr_q <= a_next;
                     if (!addr_last) begin
                        bitc_q <= bitc_q + 1'b1;
                     end else begin
                        bitc_q <= '0;
                        case (seep_op_e'(opc_q))
                           OP_READ: begin
                              rsh_q    <= rd_data_i;
                              rd_en_q  <= 1'b1;
                              rd_bit_q <= 1'b0;
                              state_q  <= ST_READ;
                           end
                           OP_WRITE: begin
                              state_q <= ST_DATA;
                           end
                           OP_ERASE: begin
                              state_q <= ST_HOLD;
                              if (wel_q) begin
                                 we_one_q <= 1'b1;
                                 wa_q     <= a_next;
                                 wd_q     <= '1;
                              end
                           end
                           default: begin
                              case (seep_ext_e'(ext_sel))
                                 EX_UNLOCK: begin
                                    wel_q   <= 1'b1;
                                    state_q <= ST_HOLD;
                                 end
                                 EX_LOCK: begin
                                    wel_q   <= 1'b0;
                                    state_q <= ST_HOLD;
                                 end
                                 EX_CLEAR: begin
                                    state_q <= ST_HOLD;
                                    if (wel_q) begin
                                       we_all_q <= 1'b1;
                                       wd_q     <= '1;
                                    end
                                 end
                                 default: begin
                                    state_q <= ST_DATA;
                                 end
                              endcase
                           end
                        endcase
                     end
                  end
                  ST_DATA: begin
                     data_q <= d_next;
                     if (!data_last) begin
                        bitc_q <= bitc_q + 1'b1;
                     end else begin
                        state_q <= ST_HOLD;
                        if (wel_q) begin
                           we_one_q <= (seep_op_e'(opc_q) == OP_WRITE);
                           we_all_q <= (seep_op_e'(opc_q) != OP_WRITE);
                           wa_q     <= addr_q;
                           wd_q     <= d_next;
                        end
                     end
                  end
                  ST_READ: begin
                     rd_bit_q <= rsh_q[DW-1];
                     rsh_q    <= {rsh_q[DW-2:0], 1'b0};
                  end
                  default: begin
                  end
               endcase
            end
         end
      end
   end

   assign we_one_o  = we_one_q;
   assign we_all_o  = we_all_q;
   assign wr_addr_o = wa_q;
   assign wr_data_o = wd_q;
   assign do_en_o   = poll_q | rd_en_q;
   assign do_o      = poll_q ? ~busy_i : rd_bit_q;

   AST_PROG_NEEDS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_one_q || we_all_q) |-> wel_q) else $error("array modified with latch clear"); // R9
   AST_DESELECT_RELEASES_DO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_i |=> !do_en_o) else $error("DO still driven after deselect"); // R12
   AST_POLL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(poll_q) |-> ($past(busy_i) && $past(cs_i) && !$past(cs_i, 2))) else $error("status mode entered without busy select toggle"); // R11
   AST_READ_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_en_q) |-> !$past(busy_i)) else $error("read accepted during busy window"); // R3

endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
   import seep_pkg::*;
#(
   parameter bit          WORD16       = 1'b0,
   parameter int unsigned NARROW_AW    = 7,
   parameter int unsigned TPROG_CYCLES = 40
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic do_o,
   output logic do_en_o
);

   localparam int unsigned AW = addr_width(WORD16, NARROW_AW);
   localparam int unsigned DW = word_width(WORD16);

   initial begin : g_param_chk
      assert (NARROW_AW >= 4 && NARROW_AW <= 12)
         else $error("NARROW_AW out of supported range");
      assert (TPROG_CYCLES >= 1)
         else $error("TPROG_CYCLES must be at least one");
   end

   logic          sk_rise;
   logic          cs_rise;
   logic          busy;
   logic          we_one;
   logic          we_all;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;

   seep_pin_edges u_edges (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cs_i      (cs_i),
      .sk_i      (sk_i),
      .sk_rise_o (sk_rise),
      .cs_rise_o (cs_rise)
   );

   seep_cmd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cs_i      (cs_i),
      .di_i      (di_i),
      .sk_rise_i (sk_rise),
      .cs_rise_i (cs_rise),
      .busy_i    (busy),
      .rd_data_i (rd_data),
      .rd_addr_o (rd_addr),
      .we_one_o  (we_one),
      .we_all_o  (we_all),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .do_en_o   (do_en_o),
      .do_o      (do_o)
   );

   seep_prog_timer #(.TPROG_CYCLES(TPROG_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (we_one | we_all),
      .busy_o  (busy)
   );

   seep_array #(.AW(AW), .DW(DW)) u_array (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_one_i  (we_one),
      .we_all_i  (we_all),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

endmodule

// File: tb/serial_eeprom_bench.sv
module serial_eeprom_bench;

   localparam int AW = 7;
   localparam int DW = 8;
   localparam int T  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sk = 1'b0;
   logic di = 1'b0;
   wire  do_o;
   wire  do_en;

   always #4 clk = ~clk;

   serial_eeprom #(.WORD16(1'b0), .NARROW_AW(7), .TPROG_CYCLES(T)) u_serial_eeprom (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .cs_i    (cs),
      .sk_i    (sk),
      .di_i    (di),
      .do_o    (do_o),
      .do_en_o (do_en)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string req = "R1";
   bit    running = 1'b0;
   bit    finished = 1'b0;

   logic  t_en = 1'b0;
   logic  t_do = 1'b0;
   int    m_cnt = 0;
   bit    m_poll = 1'b0;
   bit    m_csp = 1'b0;
   bit    start_pend = 1'b0;
   logic [DW-1:0] exp_mem [0:(1<<AW)-1];

   task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural model of the busy window and status selection
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  = 0;
         m_poll = 1'b0;
         m_csp  = 1'b0;
      end else begin
         if (!cs) m_poll = 1'b0;
         else if (!m_csp && m_cnt != 0) m_poll = 1'b1;
         if (start_pend) begin
            m_cnt = T;
            start_pend = 1'b0;
         end else if (m_cnt > 0) begin
            m_cnt--;
         end
         m_csp = cs;
      end
   end

   always @(negedge clk) begin
      logic ee;
      logic ed;
      if (rst_n && running && !finished) begin
         ee = m_poll | t_en;
         ed = m_poll ? (m_cnt == 0) : t_do;
         chk(do_en === ee && (!ee || do_o === ed), "DO per clock",
             {14'd0, do_en, do_o}, {14'd0, ee, ed});
      end
   end

   task automatic sbit(input logic b, input logic nen = 1'b0, input logic ndo = 1'b0);
      @(negedge clk); di = b; sk = 1'b0;
      @(negedge clk); sk = 1'b1;
      @(posedge clk); t_en = nen; t_do = ndo;
      @(negedge clk);
   endtask

   task automatic select_cs();
      @(negedge clk); cs = 1'b1; sk = 1'b0;
   endtask

   task automatic deselect();
      @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
      @(posedge clk); t_en = 1'b0; t_do = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic shift_cmd(input logic [1:0] opc, input logic [AW-1:0] a, input bit withd,
                            input logic [DW-1:0] d, input int lead);
      for (int i = 0; i < lead; i++) sbit(1'b0);
      sbit(1'b1);
      sbit(opc[1]);
      sbit(opc[0]);
      for (int i = AW - 1; i >= 0; i--) sbit(a[i]);
      if (withd) for (int i = DW - 1; i >= 0; i--) sbit(d[i]);
   endtask

   task automatic run_cmd(input logic [1:0] opc, input logic [AW-1:0] a, input bit withd,
                          input logic [DW-1:0] d, input bit progs);
      select_cs();
      shift_cmd(opc, a, withd, d, 0);
      if (progs) start_pend = 1'b1;
      deselect();
   endtask

   task automatic wait_prog();
      repeat (T + 4) @(negedge clk);
   endtask

   task automatic read_word(input logic [AW-1:0] a, input int lead = 0);
      logic [DW-1:0] e;
      e = exp_mem[a];
      select_cs();
      for (int i = 0; i < lead; i++) sbit(1'b0);
      sbit(1'b1);
      sbit(1'b1);
      sbit(1'b0);
      for (int i = AW - 1; i >= 1; i--) sbit(a[i]);
      sbit(a[0], 1'b1, 1'b0);
      for (int i = DW - 1; i >= 0; i--) sbit(1'b0, 1'b1, e[i]);
      deselect();
   endtask

   function automatic logic [AW-1:0] ext(input logic [1:0] s);
      return {s, {(AW-2){1'b0}}};
   endfunction

   task automatic fill_exp(input logic [DW-1:0] v);
      for (int i = 0; i < (1 << AW); i++) exp_mem[i] = v;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
   end

   initial begin
      fill_exp(8'hFF);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);

      // R1: reset state
      req = "R1";
      chk(do_en === 1'b0, "DO released after reset", {15'd0, do_en}, 16'd0);
      read_word(7'h00);
      read_word(7'h7F);

      // R9: latch clear after reset, modifying commands ignored
      req = "R9";
      run_cmd(2'b01, 7'h05, 1'b1, 8'hA5, 1'b0);
      run_cmd(2'b11, 7'h06, 1'b0, 8'h00, 1'b0);
      read_word(7'h05);

      // R12: select with nothing running
      req = "R12";
      select_cs();
      repeat (3) @(negedge clk);
      chk(do_en === 1'b0, "DO not driven when idle", {15'd0, do_en}, 16'd0);
      deselect();

      // R6: set write-enable latch
      req = "R6";
      run_cmd(2'b00, ext(2'b11), 1'b0, 8'h00, 1'b0);

      // R2 and R4: write preceded by leading zeros, then poll
      req = "R2";
      select_cs();
      shift_cmd(2'b01, 7'h05, 1'b1, 8'hA5, 2);
      start_pend = 1'b1;
      deselect();
      exp_mem[5] = 8'hA5;
      req = "R11";
      select_cs();
      @(negedge clk);
      chk(do_en === 1'b1 && do_o === 1'b0, "busy shown after toggle",
          {14'd0, do_en, do_o}, 16'h0002);
      req = "R10";
      shift_cmd(2'b01, 7'h09, 1'b1, 8'h3C, 0);
      req = "R11";
      chk(do_en === 1'b1 && do_o === 1'b1, "ready shown after window",
          {14'd0, do_en, do_o}, 16'h0003);
      deselect();
      req = "R4";
      read_word(7'h05);
      req = "R11";
      read_word(7'h09);
      req = "R2";
      read_word(7'h05, 3);

      // R4: boundary addresses
      req = "R4";
      run_cmd(2'b01, 7'h7F, 1'b1, 8'h5A, 1'b1);
      wait_prog();
      exp_mem[127] = 8'h5A;
      read_word(7'h7F);
      run_cmd(2'b01, 7'h00, 1'b1, 8'h81, 1'b1);
      wait_prog();
      exp_mem[0] = 8'h81;
      read_word(7'h00);

      // R12: poll after window already over
      req = "R12";
      select_cs();
      repeat (3) @(negedge clk);
      chk(do_en === 1'b0, "no status after window ended", {15'd0, do_en}, 16'd0);
      deselect();

      // R5: erase one word
      req = "R5";
      run_cmd(2'b11, 7'h7F, 1'b0, 8'h00, 1'b1);
      wait_prog();
      exp_mem[127] = 8'hFF;
      read_word(7'h7F);
      read_word(7'h00);

      // R8: fill whole array
      req = "R8";
      run_cmd(2'b00, ext(2'b01), 1'b1, 8'h3C, 1'b1);
      wait_prog();
      fill_exp(8'h3C);
      read_word(7'h00);
      read_word(7'h40);
      read_word(7'h7F);

      // R7: erase whole array
      req = "R7";
      run_cmd(2'b00, ext(2'b10), 1'b0, 8'h00, 1'b1);
      wait_prog();
      fill_exp(8'hFF);
      read_word(7'h00);
      read_word(7'h7F);

      req = "R4";
      run_cmd(2'b01, 7'h03, 1'b1, 8'h81, 1'b1);
      wait_prog();
      exp_mem[3] = 8'h81;

      // R6: clear latch, then R9: everything blocked
      req = "R6";
      run_cmd(2'b00, ext(2'b00), 1'b0, 8'h00, 1'b0);
      req = "R9";
      run_cmd(2'b11, 7'h03, 1'b0, 8'h00, 1'b0);
      run_cmd(2'b00, ext(2'b01), 1'b1, 8'h55, 1'b0);
      run_cmd(2'b00, ext(2'b10), 1'b0, 8'h00, 1'b0);
      run_cmd(2'b01, 7'h03, 1'b1, 8'h00, 1'b0);
      read_word(7'h0A);

      // R3: read still works with latch clear
      req = "R3";
      read_word(7'h03);
      read_word(7'h00);

      repeat (4) @(negedge clk);
      summary();
   end

endmodule